// File: doc/BRIEF.md
# Cascaded Voltage/Current Loop Controller

This block is the arithmetic core of an average-current-mode regulator for a step-down power stage. It runs two compensators in a cascade on 16-bit signed fixed-point data. The outer stage works on the output-voltage error. Its clamped result becomes the reference for the inner stage, which works on the inductor-current error. The inner stage's clamped result is the new PWM duty value.

A start strobe opens one control cycle. The block takes in the voltage reference and the current sample at that point. It then evaluates everything in the outer compensator that depends only on stored history, and waits for the voltage conversion to finish. When the sample is flagged valid, only one product and one add remain for the outer stage. The inner stage follows in the next cycle.

Each compensator is a 2-pole/2-zero direct-form filter with Q15 coefficients and a saturating 32-bit accumulator. Each stage clamps its result to its own window and stores the clamped value in its history, so it does not wind up. An enable input switches the loop off. While the loop is off, the duty output holds its value and both histories are cleared.

Top module: `cascade_loop`

## Requirements
- R1: Outer error is vRef minus vSample, both as captured for the cycle, saturated to the 16-bit signed range. vRef is captured at the accepted start strobe. vSample is captured in the cycle where vSampleValid is high in the wait phase.
- R2: Each stage computes acc = B0·e[n]+B1·e[n−1]+B2·e[n−2]+A1·y[n−1]+A2·y[n−2]. Coefficients are Q15, supplied as a 5-entry array with index 0..4 = B0,B1,B2,A1,A2. The four history terms are summed and saturated to 32 bits. B0·e[n] is then added and the total saturated to 32 bits again. The stage result is acc arithmetically shifted right by 15, then saturated to 16 bits.
- R3: The outer result is clamped to [vMin, vMax]: above vMax gives vMax, below vMin gives vMin. The clamped value is the one stored as y[n−1].
- R4: The inner error is the clamped outer result minus iSample as captured at the accepted start strobe, saturated to 16 bits.
- R5: The inner result is clamped to [iMin, iMax] and is stored as the inner y[n−1]. The clamped value is driven on duty.
- R6: duty changes and done is high for exactly one cycle after the third rising edge that counts from the edge at which vSampleValid is sampled high. duty changes at no other time.
- R7: The history-only part of the outer filter is evaluated before the voltage sample. vSample is read only in the valid cycle, so later changes to it have no effect on the result.
- R8: While enable is low, start and vSampleValid are ignored, done stays low, duty holds its value, and both filter histories are cleared. The first cycle after re-enabling therefore behaves as if all histories were zero.
- R9: After reset, duty is 0 and done is 0.
- R10: A start strobe received while a cycle is in progress is ignored. Each cycle produces exactly one done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Loop on (1) or bypassed with histories cleared (0) |
| start | input | 1 | Opens one control cycle |
| vRef | input | 16 | Voltage reference, signed |
| vSample | input | 16 | Voltage ADC result, signed |
| vSampleValid | input | 1 | vSample is valid this cycle |
| iSample | input | 16 | Current ADC result taken mid on-time, signed |
| vMin | input | 16 | Outer clamp minimum, signed |
| vMax | input | 16 | Outer clamp maximum, signed |
| iMin | input | 16 | Inner clamp minimum, signed |
| iMax | input | 16 | Inner clamp maximum, signed |
| vCoef | input | 5x16 | Outer Q15 coefficients B0,B1,B2,A1,A2 |
| iCoef | input | 5x16 | Inner Q15 coefficients B0,B1,B2,A1,A2 |
| duty | output | 16 | Clamped inner result, signed |
| done | output | 1 | One-cycle strobe when duty is updated |

## Verification
An integrating outer stage is driven into its upper clamp and then given a reversed error. A design that stored the unclamped value would wind up, and its duty would lag the model for several cycles after the reversal. Full-scale references and all-maximum coefficients push both the error subtraction and the 32-bit sums past their limits; wrapping instead of saturating shows up as a duty of the wrong sign. The bench changes vSample after the valid cycle and sends a second start during a cycle, which catches a design that samples late or starts a second cycle. A disable-and-re-enable sequence checks that duty is held and that the next result matches a fresh loop.

// File: rtl/cascade_pkg.sv
package cascade_pkg;
  localparam int DATA_W = 16;
  localparam int COEF_W = 16;
  localparam int ACC_W  = 32;
  localparam int NTAP   = 5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRECOMP, ST_WAIT_V, ST_OUTER, ST_INNER, ST_DONE
  } loop_state_t;

  typedef struct packed {
    logic clear;
    logic captureIn;
    logic precomp;
    logic captureV;
    logic runOuter;
    logic runInner;
  } loop_strobe_t;
endpackage

// File: rtl/cascade_comp.sv
module cascade_comp #(
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int AW = 32,
  parameter int NT = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 clear,
  input  logic                 precomp,
  input  logic                 run,
  input  logic [NT-1:0][CW-1:0] coef,
  input  logic signed [DW-1:0] err,
  input  logic signed [DW-1:0] lo,
  input  logic signed [DW-1:0] hi,
  output logic signed [DW-1:0] yNext,
  output logic signed [DW-1:0] yOut
);
  localparam int PW = DW + CW;
  localparam int SW = AW + 4;
  localparam int FRAC = CW - 1;
  localparam logic signed [SW-1:0] ACC_MAX = {{5{1'b0}}, {(AW-1){1'b1}}};
  localparam logic signed [SW-1:0] ACC_MIN = {{5{1'b1}}, {(AW-1){1'b0}}};
  localparam logic signed [AW-1:0] OUT_MAX = AW'({1'b0, {(DW-1){1'b1}}});
  localparam logic signed [AW-1:0] OUT_MIN = -OUT_MAX - AW'(1);

  function automatic logic signed [AW-1:0] satAcc(input logic signed [SW-1:0] v);
    if (v > ACC_MAX) return ACC_MAX[AW-1:0];
    if (v < ACC_MIN) return ACC_MIN[AW-1:0];
    return v[AW-1:0];
  endfunction

  logic signed [DW-1:0] e1, e2, y1, y2;
  logic signed [AW-1:0] partial;
  logic signed [CW-1:0] cB0, cB1, cB2, cA1, cA2;
  logic signed [PW-1:0] pB0, pB1, pB2, pA1, pA2;
  logic signed [SW-1:0] histSum, fullSum;
  logic signed [AW-1:0] accFull, shifted;
  logic signed [DW-1:0] yRaw;

  always_comb begin
    cB0 = $signed(coef[0]);
    cB1 = $signed(coef[1]);
    cB2 = $signed(coef[2]);
    cA1 = $signed(coef[3]);
    cA2 = $signed(coef[4]);
    pB0 = cB0 * err;
    pB1 = cB1 * e1;
    pB2 = cB2 * e2;
    pA1 = cA1 * y1;
    pA2 = cA2 * y2;
    histSum = SW'(pB1) + SW'(pB2) + SW'(pA1) + SW'(pA2);
    fullSum = SW'(partial) + SW'(pB0);
    accFull = satAcc(fullSum);
    shifted = accFull >>> FRAC;
    if (shifted > OUT_MAX)      yRaw = OUT_MAX[DW-1:0];
    else if (shifted < OUT_MIN) yRaw = OUT_MIN[DW-1:0];
    else                        yRaw = shifted[DW-1:0];
    if (yRaw > hi)      yNext = hi;
    else if (yRaw < lo) yNext = lo;
    else                yNext = yRaw;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      e1 <= '0; e2 <= '0; y1 <= '0; y2 <= '0; partial <= '0;
    end else if (clear) begin
      e1 <= '0; e2 <= '0; y1 <= '0; y2 <= '0; partial <= '0;
    end else begin
      if (precomp) partial <= satAcc(histSum);
      if (run) begin
        e2 <= e1;
        e1 <= err;
        y2 <= y1;
        y1 <= yNext;
      end
    end
  end

  assign yOut = y1;
endmodule

// File: rtl/cascade_ctrl.sv
module cascade_ctrl
  import cascade_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         enable,
  input  logic         start,
  input  logic         vSampleValid,
  output loop_strobe_t strobe,
  output logic         done
);
  loop_state_t state, stateNext;

  always_comb begin
    strobe = '0;
    stateNext = state;
    if (!enable) begin
      strobe.clear = 1'b1;
      stateNext = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          strobe.captureIn = 1'b1;
          stateNext = ST_PRECOMP;
        end
        ST_PRECOMP: begin
          strobe.precomp = 1'b1;
          stateNext = ST_WAIT_V;
        end
        ST_WAIT_V: if (vSampleValid) begin
          strobe.captureV = 1'b1;
          stateNext = ST_OUTER;
        end
        ST_OUTER: begin
          strobe.runOuter = 1'b1;
          stateNext = ST_INNER;
        end
        ST_INNER: begin
          strobe.runInner = 1'b1;
          stateNext = ST_DONE;
        end
        ST_DONE: stateNext = ST_IDLE;
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign done = (state == ST_DONE);
endmodule

// File: rtl/cascade_datapath.sv
module cascade_datapath
  import cascade_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = COEF_W,
  parameter int AW = ACC_W,
  parameter int NT = NTAP
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  loop_strobe_t          strobe,
  input  logic signed [DW-1:0]  vRef,
  input  logic signed [DW-1:0]  vSample,
  input  logic signed [DW-1:0]  iSample,
  input  logic signed [DW-1:0]  vMin,
  input  logic signed [DW-1:0]  vMax,
  input  logic signed [DW-1:0]  iMin,
  input  logic signed [DW-1:0]  iMax,
  input  logic [NT-1:0][CW-1:0] vCoef,
  input  logic [NT-1:0][CW-1:0] iCoef,
  output logic signed [DW-1:0]  duty
);
  localparam logic signed [DW:0] E_MAX = {2'b00, {(DW-1){1'b1}}};
  localparam logic signed [DW:0] E_MIN = {2'b11, {(DW-1){1'b0}}};

  function automatic logic signed [DW-1:0] satErr(input logic signed [DW:0] v);
    if (v > E_MAX) return E_MAX[DW-1:0];
    if (v < E_MIN) return E_MIN[DW-1:0];
    return v[DW-1:0];
  endfunction

  logic signed [DW-1:0] vRefCap, vCap, iCap;
  logic signed [DW-1:0] outerErr, innerErr;
  logic signed [DW-1:0] outerNext, outerY, innerNext, innerY;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vRefCap <= '0; vCap <= '0; iCap <= '0; duty <= '0;
    end else begin
      if (strobe.captureIn) begin
        vRefCap <= vRef;
        iCap    <= iSample;
      end
      if (strobe.captureV) vCap <= vSample;
      if (strobe.runInner) duty <= innerNext;
    end
  end

  assign outerErr = satErr((DW+1)'(vRefCap) - (DW+1)'(vCap));
  assign innerErr = satErr((DW+1)'(outerY) - (DW+1)'(iCap));

  cascade_comp #(.DW(DW), .CW(CW), .AW(AW), .NT(NT)) u_outer (
    .clk(clk), .rstN(rstN), .clear(strobe.clear), .precomp(strobe.precomp),
    .run(strobe.runOuter), .coef(vCoef), .err(outerErr), .lo(vMin), .hi(vMax),
    .yNext(outerNext), .yOut(outerY)
  );

  cascade_comp #(.DW(DW), .CW(CW), .AW(AW), .NT(NT)) u_inner (
    .clk(clk), .rstN(rstN), .clear(strobe.clear), .precomp(strobe.precomp),
    .run(strobe.runInner), .coef(iCoef), .err(innerErr), .lo(iMin), .hi(iMax),
    .yNext(innerNext), .yOut(innerY)
  );
endmodule

// File: rtl/cascade_loop.sv
module cascade_loop
  import cascade_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         enable,
  input  logic                         start,
  input  logic signed [DATA_W-1:0]     vRef,
  input  logic signed [DATA_W-1:0]     vSample,
  input  logic                         vSampleValid,
  input  logic signed [DATA_W-1:0]     iSample,
  input  logic signed [DATA_W-1:0]     vMin,
  input  logic signed [DATA_W-1:0]     vMax,
  input  logic signed [DATA_W-1:0]     iMin,
  input  logic signed [DATA_W-1:0]     iMax,
  input  logic [NTAP-1:0][COEF_W-1:0]  vCoef,
  input  logic [NTAP-1:0][COEF_W-1:0]  iCoef,
  output logic signed [DATA_W-1:0]     duty,
  output logic                         done
);
  loop_strobe_t strobe;

  cascade_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .start(start),
    .vSampleValid(vSampleValid), .strobe(strobe), .done(done)
  );

  cascade_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .vRef(vRef), .vSample(vSample),
    .iSample(iSample), .vMin(vMin), .vMax(vMax), .iMin(iMin), .iMax(iMax),
    .vCoef(vCoef), .iCoef(iCoef), .duty(duty)
  );
endmodule

// File: rtl/cascade_loop_chk.sv
module cascade_loop_chk
  import cascade_pkg::*;
(
  input logic                     clk,
  input logic                     rstN,
  input logic                     enable,
  input logic                     done,
  input logic signed [DATA_W-1:0] duty,
  input logic signed [DATA_W-1:0] iMin,
  input logic signed [DATA_W-1:0] iMax
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R6

  AST_DUTY_MOVES_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(duty) |-> done); // R6

  AST_DUTY_IN_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    (done && (iMin <= iMax)) |-> (duty >= iMin && duty <= iMax)); // R5

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> $stable(duty)); // R8

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !done); // R8

  always @(posedge clk)
    if (!rstN) AST_RESET_STATE: assert (!done); // R9
endmodule

bind cascade_loop cascade_loop_chk u_chk (.*);

// File: tb/cascade_loop_bench.sv
module cascade_loop_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0, start = 1'b0, vSampleValid = 1'b0;
  logic signed [15:0] vRef = '0, vSample = '0, iSample = '0;
  logic signed [15:0] vMin = -16'sd32768, vMax = 16'sd32767;
  logic signed [15:0] iMin = -16'sd32768, iMax = 16'sd32767;
  logic [4:0][15:0] vCoef = '0, iCoef = '0;
  logic signed [15:0] duty;
  logic done;

  int errors = 0, checks = 0;
  int cycles = 0;

  // bench model state: [0] outer, [1] inner
  longint hE1[2], hE2[2], hY1[2], hY2[2];
  logic signed [15:0] expDuty = '0;

  cascade_loop u_cascade_loop (.*);

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint sat(input longint v, input int bits);
    longint mx = (longint'(1) <<< (bits - 1)) - 1;
    if (v > mx) return mx;
    if (v < -mx - 1) return -mx - 1;
    return v;
  endfunction

  function automatic longint cf(input logic [4:0][15:0] c, input int k);
    return longint'($signed(c[k]));
  endfunction

  function automatic longint stageStep(input int s, input logic [4:0][15:0] c,
                                       input longint e, input longint lo, input longint hi);
    longint part, full, y;
    part = sat(cf(c,1)*hE1[s] + cf(c,2)*hE2[s] + cf(c,3)*hY1[s] + cf(c,4)*hY2[s], 32);
    full = sat(part + cf(c,0)*e, 32);
    y = sat(full >>> 15, 16);
    if (y > hi) y = hi;
    else if (y < lo) y = lo;
    hE2[s] = hE1[s]; hE1[s] = e; hY2[s] = hY1[s]; hY1[s] = y;
    return y;
  endfunction

  task automatic modelClear();
    for (int s = 0; s < 2; s++) begin
      hE1[s] = 0; hE2[s] = 0; hY1[s] = 0; hY2[s] = 0;
    end
  endtask

  // one full control cycle with latency and duty checks
  task automatic runCycle(input longint r, input longint vs, input longint is,
                          input bit poke, input string tag);
    longint eo, yo, ei;
    int wait_n;
    @(negedge clk);
    vRef = 16'(r); iSample = 16'(is); start = 1'b1;
    @(negedge clk); start = 1'b0;
    iSample = 16'(is + 123);       // current captured at start only (R4)
    @(negedge clk);
    if (poke) start = 1'b1;        // second start mid-cycle (R10)
    vRef = 16'(r + 77);            // reference captured at start only (R1)
    vSample = 16'(vs); vSampleValid = 1'b1;
    @(negedge clk);
    vSampleValid = 1'b0; start = 1'b0;
    if (poke) vSample = 16'(vs - 999);   // late change ignored (R7)
    wait_n = 1;
    while (!done && wait_n < 10) begin
      @(negedge clk); wait_n++;
    end
    eo = sat(r - vs, 16);
    yo = stageStep(0, vCoef, eo, vMin, vMax);
    ei = sat(yo - is, 16);
    expDuty = 16'(stageStep(1, iCoef, ei, iMin, iMax));
    check({"R6 latency ", tag}, wait_n, 3);
    check({"R2 R3 R5 duty ", tag}, duty, expDuty);
    @(negedge clk);
    check({"R6 done one cycle ", tag}, done, 0);
  endtask

  task automatic offCycle();
    @(negedge clk); enable = 1'b0;
    @(negedge clk); enable = 1'b1;
    modelClear();
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R9 duty after reset", duty, 0);
    check("R9 done after reset", done, 0);
  endtask

  task automatic testProportional();
    offCycle();
    vCoef = '0; iCoef = '0;
    vCoef[0] = 16'd16384; iCoef[0] = 16'd16384;
    runCycle(1000, 600, 100, 0, "prop a");
    check("R1 R4 prop duty value", duty, 50);
    runCycle(-2000, 0, -300, 0, "prop b");
    runCycle(500, 700, 40, 0, "prop c");
    check("R4 prop negative duty", duty, -70);
  endtask

  task automatic testWindup();
    offCycle();
    vCoef = '0; iCoef = '0;
    vCoef[0] = 16'd8192; vCoef[3] = 16'd32767; iCoef[0] = 16'd32767;
    vMax = 16'sd3000; vMin = -16'sd3000;
    for (int k = 0; k < 5; k++) runCycle(8000, 0, 0, 0, "windup up R3");
    runCycle(-4000, 0, 0, 0, "windup reverse R3");
    runCycle(-4000, 0, 0, 0, "windup reverse2 R3");
    vMax = 16'sd32767; vMin = -16'sd32768;
  endtask

  task automatic testSaturation();
    offCycle();
    for (int k = 0; k < 5; k++) vCoef[k] = 16'd32767;
    iCoef = '0; iCoef[0] = 16'd32767;
    runCycle(32767, -32768, 0, 0, "sat R1 first");
    runCycle(32767, -32768, -32768, 0, "sat R2 acc");
    runCycle(-32768, 32767, 32767, 0, "sat R2 flip");
  endtask

  task automatic testInnerClamp();
    offCycle();
    vCoef = '0; iCoef = '0;
    vCoef[0] = 16'd32767; iCoef[0] = 16'd32767;
    iMin = -16'sd500; iMax = 16'sd900;
    runCycle(0, 4000, 0, 0, "clamp low");
    check("R5 duty at iMin", duty, -500);
    runCycle(4000, 0, 0, 0, "clamp high");
    check("R5 duty at iMax", duty, 900);
    iMin = -16'sd32768; iMax = 16'sd32767;
  endtask

  task automatic testLateAndRestart();
    offCycle();
    vCoef = '0; iCoef = '0;
    vCoef[0] = 16'd16384; vCoef[1] = 16'd8192; iCoef[0] = 16'd16384;
    runCycle(3000, 1000, 200, 1, "poke R7 R10");
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      check("R10 no extra done", done, 0);
    end
    runCycle(2500, 500, -100, 1, "poke2 R7 R10");
  endtask

  task automatic testDisable();
    logic signed [15:0] held;
    int seen = 0;
    held = duty;
    @(negedge clk); enable = 1'b0;
    for (int k = 0; k < 12; k++) begin
      start = (k % 3 == 0); vSampleValid = (k % 3 == 2); vSample = 16'(k * 100);
      @(negedge clk);
      if (done) seen++;
    end
    start = 1'b0; vSampleValid = 1'b0;
    check("R8 no done while off", seen, 0);
    check("R8 duty held while off", duty, held);
    enable = 1'b1;
    modelClear();
    runCycle(3000, 1000, 200, 0, "R8 fresh restart");
  endtask

  initial begin
    modelClear();
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    enable = 1'b1;
    testProportional();
    testWindup();
    testSaturation();
    testInnerClamp();
    testLateAndRestart();
    testDisable();
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule